// File: doc/BRIEF.md
# Prioritized Local-to-PCI Address Window Translator

This block maps each local-bus access address onto a PCI bus address through three programmable windows. Two general windows serve memory-type traffic and carry a power-of-two size, a PCI cycle type, a prefetch attribute, a swap attribute and a choice of how PCI address bits 1:0 are formed. A third window has a fixed 16 MB span, a narrower register format, and always produces I/O cycles.

Windows may overlap. The lowest-numbered enabled window that covers the address wins. This lets software enlarge window 0 so that it hides window 1, and then reprogram window 1, for example as a configuration aperture, without a gap in memory coverage. Each request returns one registered result a cycle later. The result holds the hit flag, the winning window index, the translated address, the cycle type and the attributes. A small write/read port programs the six window registers.

Top module: `addr_window_xlat`

## Requirements
- R1: After reset every window register reads 0, every window is disabled, and `rsp_valid`, `rsp_hit` and all response fields are 0.
- R2: `reg_sel` selects a register: 0 = memory window 0 base (32 bits), 1 = memory window 0 map (16 bits), 2 = memory window 1 base, 3 = memory window 1 map, 4 = I/O window base (16 bits), 5 = I/O window map (16 bits). A write stores the low bits of `reg_wdata` that fit the register. `reg_rdata` returns the selected register, zero-extended. Selects 6 and 7 read as 0, and writes to them change no register.
- R3: In a memory base register, bits 31:20 hold the local base, bits 9:8 the swap code, bits 7:4 the size code, bit 3 prefetchable and bit 0 enable. Size code n (0..11) gives a span of 2^(20+n) bytes. The window covers an address when it is enabled and the address bits at and above bit 20+n equal the same base bits.
- R4: For a memory-window hit, the PCI address bits at and above bit 20+n come from map register bits 15:4, which stand for PCI bits 31:20. The lower bits, down to bit 2, are copied from the local address.
- R5: Map register bit 0 is the low-address enable. When it is 1, PCI address bits 1:0 follow the local address. When it is 0, they are 00.
- R6: The cycle type of a memory-window hit is map bits 3:1 (000 interrupt-acknowledge, 001 I/O, 011 memory, 101 configuration, 110 memory-multiple). Prefetch and swap come from that window's base register. An I/O-window hit reports type 001, prefetch 0, and swap from I/O base bits 7:6.
- R7: The I/O window is enabled by I/O base bit 0. It covers a 16 MB span when local address bits 31:24 equal I/O base bits 15:8. Its PCI address is I/O map bits 15:8 followed by local address bits 23:0.
- R8: When several enabled windows cover an address, the lowest index wins (0, then 1, then the I/O window as index 2). `rsp_win` reports that index.
- R9: A memory window whose size code is 12 to 15 never covers any address.
- R10: A request that no window covers gives `rsp_hit` 0 and zero on `rsp_win`, `rsp_pci_addr`, `rsp_type`, `rsp_prefetch` and `rsp_swap`.
- R11: The response for a request in cycle t appears after the next clock edge. `rsp_valid` equals the previous cycle's `req_valid`, and without a request `rsp_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Local-bus address |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Some window covered the address |
| rsp_win | output | 2 | Index of the winning window |
| rsp_pci_addr | output | 32 | Translated PCI address |
| rsp_type | output | 3 | PCI cycle type |
| rsp_prefetch | output | 1 | Prefetchable attribute |
| rsp_swap | output | 2 | Swap attribute |

## Verification
The assertions assume that registers are not rewritten in the same cycle as a request whose result is checked. They also assume that `req_addr` is stable while `req_valid` is high. The bench writes the windows only between requests and holds each address for one full cycle. The sweeps cover every size code, including the reserved ones, overlapping and disjoint layouts, and every high address nibble. Addresses sit on window edges (first byte, last byte, one past the end, one before the start). The expected results come from division and remainder on the programmed values.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int ADDR_W      = 32;
    localparam int MAP_W       = 16;
    localparam int MIN_SHIFT   = 20;
    localparam int HI_W        = ADDR_W - MIN_SHIFT;
    localparam int MAX_SIZE    = 11;
    localparam int IO_SHIFT    = 24;
    localparam int IO_HI_W     = ADDR_W - IO_SHIFT;
    localparam logic [2:0] CT_IO = 3'b001;

    typedef struct packed {
        logic              match;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        ctype;
        logic              prefetch;
        logic [1:0]        swap;
    } win_res_t;

endpackage

// File: rtl/xlat_regs.sv
module xlat_regs
    import xlat_pkg::*;
#(
    parameter int NUM_MEM_WIN = 2,
    parameter int SEL_W       = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  we,
    input  logic [SEL_W-1:0]                      sel,
    input  logic [ADDR_W-1:0]                     wdata,
    output logic [ADDR_W-1:0]                     rdata,
    output logic [NUM_MEM_WIN-1:0][ADDR_W-1:0]    mem_base,
    output logic [NUM_MEM_WIN-1:0][MAP_W-1:0]     mem_map,
    output logic [MAP_W-1:0]                      io_base,
    output logic [MAP_W-1:0]                      io_map
);

    localparam int IO_BASE_SEL = 2 * NUM_MEM_WIN;
    localparam int IO_MAP_SEL  = IO_BASE_SEL + 1;

    typedef struct packed {
        logic [NUM_MEM_WIN-1:0][ADDR_W-1:0] mbase;
        logic [NUM_MEM_WIN-1:0][MAP_W-1:0]  mmap;
        logic [MAP_W-1:0]                   ibase;
        logic [MAP_W-1:0]                   imap;
    } regs_t;

    regs_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we) begin
            for (int w = 0; w < NUM_MEM_WIN; w++) begin
                if (int'(sel) == 2 * w)     state_d.mbase[w] = wdata;
                if (int'(sel) == 2 * w + 1) state_d.mmap[w]  = wdata[MAP_W-1:0];
            end
            if (int'(sel) == IO_BASE_SEL) state_d.ibase = wdata[MAP_W-1:0];
            if (int'(sel) == IO_MAP_SEL)  state_d.imap  = wdata[MAP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < NUM_MEM_WIN; w++) begin
            if (int'(sel) == 2 * w)     rdata = state_q.mbase[w];
            if (int'(sel) == 2 * w + 1) rdata = {{(ADDR_W-MAP_W){1'b0}}, state_q.mmap[w]};
        end
        if (int'(sel) == IO_BASE_SEL) rdata = {{(ADDR_W-MAP_W){1'b0}}, state_q.ibase};
        if (int'(sel) == IO_MAP_SEL)  rdata = {{(ADDR_W-MAP_W){1'b0}}, state_q.imap};
    end

    assign mem_base = state_q.mbase;
    assign mem_map  = state_q.mmap;
    assign io_base  = state_q.ibase;
    assign io_map   = state_q.imap;

endmodule

// File: rtl/xlat_mem_win.sv
module xlat_mem_win
    import xlat_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [MAP_W-1:0]  map,
    output win_res_t          res
);

    logic [3:0]      size_code;
    logic            size_ok;
    logic [HI_W-1:0] keep_mask;
    logic [HI_W-1:0] hi_out;

    always_comb begin
        size_code = base[7:4];
        size_ok   = (size_code <= 4'(MAX_SIZE));
        for (int i = 0; i < HI_W; i++) begin
            keep_mask[i] = (i >= int'(size_code));
        end
        hi_out = (map[MAP_W-1:4] & keep_mask) | (addr[ADDR_W-1:MIN_SHIFT] & ~keep_mask);

        res.match    = base[0] && size_ok &&
                       (((addr[ADDR_W-1:MIN_SHIFT] ^ base[ADDR_W-1:MIN_SHIFT]) & keep_mask) == '0);
        res.addr     = {hi_out, addr[MIN_SHIFT-1:2], (map[0] ? addr[1:0] : 2'b00)};
        res.ctype    = map[3:1];
        res.prefetch = base[3];
        res.swap     = base[9:8];
    end

endmodule

// File: rtl/xlat_io_win.sv
module xlat_io_win
    import xlat_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [MAP_W-1:0]  base,
    input  logic [MAP_W-1:0]  map,
    output win_res_t          res
);

    always_comb begin
        res.match    = base[0] && (addr[ADDR_W-1:IO_SHIFT] == base[MAP_W-1:MAP_W-IO_HI_W]);
        res.addr     = {map[MAP_W-1:MAP_W-IO_HI_W], addr[IO_SHIFT-1:0]};
        res.ctype    = CT_IO;
        res.prefetch = 1'b0;
        res.swap     = base[7:6];
    end

endmodule

// File: rtl/addr_window_xlat.sv
module addr_window_xlat
    import xlat_pkg::*;
#(
    parameter int NUM_MEM_WIN = 2,
    parameter int SEL_W       = 3,
    localparam int NUM_WIN    = NUM_MEM_WIN + 1,
    localparam int WIN_W      = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WIN_W-1:0]  rsp_win,
    output logic [31:0]       rsp_pci_addr,
    output logic [2:0]        rsp_type,
    output logic              rsp_prefetch,
    output logic [1:0]        rsp_swap
);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [WIN_W-1:0]  win;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        ctype;
        logic              prefetch;
        logic [1:0]        swap;
    } rsp_t;

    logic [NUM_MEM_WIN-1:0][ADDR_W-1:0] mem_base;
    logic [NUM_MEM_WIN-1:0][MAP_W-1:0]  mem_map;
    logic [MAP_W-1:0]                   io_base;
    logic [MAP_W-1:0]                   io_map;
    win_res_t                           cand [NUM_WIN];

    xlat_regs #(.NUM_MEM_WIN(NUM_MEM_WIN), .SEL_W(SEL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .mem_base (mem_base),
        .mem_map  (mem_map),
        .io_base  (io_base),
        .io_map   (io_map)
    );

    for (genvar w = 0; w < NUM_MEM_WIN; w++) begin : g_mem
        xlat_mem_win u_win (
            .addr (req_addr),
            .base (mem_base[w]),
            .map  (mem_map[w]),
            .res  (cand[w])
        );
    end

    xlat_io_win u_io (
        .addr (req_addr),
        .base (io_base),
        .map  (io_map),
        .res  (cand[NUM_MEM_WIN])
    );

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            for (int w = NUM_WIN - 1; w >= 0; w--) begin
                if (cand[w].match) begin
                    rsp_d.hit      = 1'b1;
                    rsp_d.win      = WIN_W'(w);
                    rsp_d.addr     = cand[w].addr;
                    rsp_d.ctype    = cand[w].ctype;
                    rsp_d.prefetch = cand[w].prefetch;
                    rsp_d.swap     = cand[w].swap;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_hit      = rsp_q.hit;
    assign rsp_win      = rsp_q.win;
    assign rsp_pci_addr = rsp_q.addr;
    assign rsp_type     = rsp_q.ctype;
    assign rsp_prefetch = rsp_q.prefetch;
    assign rsp_swap     = rsp_q.swap;

endmodule

// File: rtl/addr_window_xlat_chk.sv
module addr_window_xlat_chk #(
    parameter int NUM_MEM_WIN = 2,
    parameter int WIN_W       = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [31:0]      req_addr,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [WIN_W-1:0] rsp_win,
    input logic [31:0]      rsp_pci_addr,
    input logic [2:0]       rsp_type,
    input logic             rsp_prefetch,
    input logic [1:0]       rsp_swap
);

    assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_no_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit));

    assert_miss_fields_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_pci_addr == 32'h0 && rsp_type == 3'b000 && !rsp_prefetch &&
                      rsp_swap == 2'b00 && rsp_win == '0));

    assert_io_attrs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && int'(rsp_win) == NUM_MEM_WIN) |-> (rsp_type == 3'b001 && !rsp_prefetch));

    assert_win_index_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (int'(rsp_win) <= NUM_MEM_WIN));

    assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_hit || rsp_pci_addr[19:2] == $past(req_addr[19:2])));

endmodule

bind addr_window_xlat addr_window_xlat_chk #(.NUM_MEM_WIN(NUM_MEM_WIN), .WIN_W(WIN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_win      (rsp_win),
    .rsp_pci_addr (rsp_pci_addr),
    .rsp_type     (rsp_type),
    .rsp_prefetch (rsp_prefetch),
    .rsp_swap     (rsp_swap)
);

// File: tb/addr_window_xlat_bench.sv
`timescale 1ns/1ps
module addr_window_xlat_bench;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_we = 0;
    logic [2:0]  reg_sel = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        req_valid = 0;
    logic [31:0] req_addr = 0;
    logic        rsp_valid, rsp_hit, rsp_prefetch;
    logic [1:0]  rsp_win, rsp_swap;
    logic [31:0] rsp_pci_addr;
    logic [2:0]  rsp_type;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_base [2];
    logic [15:0] m_map  [2];
    logic [15:0] i_base, i_map;

    always #2.5 clk = ~clk;

    addr_window_xlat u_addr_window_xlat (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_win(rsp_win), .rsp_pci_addr(rsp_pci_addr), .rsp_type(rsp_type),
        .rsp_prefetch(rsp_prefetch), .rsp_swap(rsp_swap)
    );

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_sel = 3'(sel); reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
        case (sel)
            0: m_base[0] = d;
            1: m_map[0]  = d[15:0];
            2: m_base[1] = d;
            3: m_map[1]  = d[15:0];
            4: i_base    = d[15:0];
            5: i_map     = d[15:0];
            default: ;
        endcase
    endtask

    task automatic rd(input int sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_sel = 3'(sel);
        #1;
        chk(tag, {32'h0, reg_rdata}, {32'h0, exp});
    endtask

    // Expected response packed as {hit, win, addr, type, prefetch, swap}
    function automatic logic [40:0] model(input logic [31:0] a);
        longint unsigned la = {32'h0, a};
        for (int w = 0; w < 2; w++) begin
            int sc = int'(m_base[w][7:4]);
            if (m_base[w][0] && sc <= 11) begin
                longint unsigned sz = 64'd1 << (20 + sc);
                longint unsigned lb = {32'h0, m_base[w][31:20], 20'h0};
                longint unsigned lm = {32'h0, m_map[w][15:4], 20'h0};
                if (la / sz == lb / sz) begin
                    longint unsigned p = (lm / sz) * sz + la % sz;
                    if (!m_map[w][0]) p = p - p % 4;
                    return {1'b1, 2'(w), p[31:0], m_map[w][3:1], m_base[w][3], m_base[w][9:8]};
                end
            end
        end
        if (i_base[0] && la / (64'd1 << 24) == longint'(i_base >> 8)) begin
            longint unsigned p = longint'(i_map >> 8) * (64'd1 << 24) + la % (64'd1 << 24);
            return {1'b1, 2'd2, p[31:0], 3'b001, 1'b0, i_base[7:6]};
        end
        return '0;
    endfunction

    task automatic xl(input logic [31:0] a, input string tag);
        logic [40:0] e;
        e = model(a);
        @(negedge clk);
        req_valid = 1; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        chk({tag, " valid"}, {63'h0, rsp_valid}, 64'h1);
        chk(tag, {23'h0, rsp_hit, rsp_win, rsp_pci_addr, rsp_type, rsp_prefetch, rsp_swap},
            {23'h0, e});
    endtask

    task automatic sweep_nibbles(input string tag);
        logic [27:0] offs [4] = '{28'h0000000, 28'h0ABCDE7, 28'h0FFFFFE, 28'hFFFFFFF};
        for (int n = 0; n < 16; n++)
            for (int o = 0; o < 4; o++)
                xl({4'(n), offs[o]}, tag);
    endtask

    initial begin
        m_base = '{32'h0, 32'h0}; m_map = '{16'h0, 16'h0}; i_base = 0; i_map = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rsp_valid", {63'h0, rsp_valid}, 64'h0);
        chk("R1 rsp_hit", {63'h0, rsp_hit}, 64'h0);
        chk("R1 fields", {25'h0, rsp_win, rsp_pci_addr, rsp_type, rsp_prefetch, rsp_swap}, 64'h0);
        rst_n = 1;
        for (int s = 0; s < 8; s++) rd(s, 32'h0, "R1 register reset");
        xl(32'h4000_0000, "R1 all disabled");

        // R2: register access
        wr(0, 32'hDEAD_BEEF); wr(1, 32'h1234_5678); wr(2, 32'hCAFE_F00D);
        wr(3, 32'hFFFF_ABCD); wr(4, 32'h0101_2468); wr(5, 32'h7777_1357);
        rd(0, 32'hDEAD_BEEF, "R2 sel0"); rd(1, 32'h0000_5678, "R2 sel1");
        rd(2, 32'hCAFE_F00D, "R2 sel2"); rd(3, 32'h0000_ABCD, "R2 sel3");
        rd(4, 32'h0000_2468, "R2 sel4"); rd(5, 32'h0000_1357, "R2 sel5");
        wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
        rd(6, 32'h0, "R2 sel6"); rd(7, 32'h0, "R2 sel7");
        rd(0, 32'hDEAD_BEEF, "R2 sel0 after unused"); rd(5, 32'h0000_1357, "R2 sel5 after unused");

        // R11: no request
        @(negedge clk);
        chk("R11 idle", {62'h0, rsp_valid, rsp_hit}, 64'h0);

        // Disjoint layout: R3 R4 R6 R7
        wr(0, 32'h4000_0000 | (8 << 4) | 32'h1);
        wr(1, 16'h0000 | (3'b011 << 1));
        wr(2, 32'h5000_0000 | (2 << 8) | (8 << 4) | 32'h9);
        wr(3, 16'h1000 | (3'b110 << 1) | 16'h1);
        wr(4, 16'h6000 | (1 << 6) | 16'h1);
        wr(5, 16'h2200);
        sweep_nibbles("R3 R4 R5 R6 R7 disjoint");

        // Overlap: R8 window 0 512MB hides window 1 configuration aperture
        wr(0, 32'h4000_0000 | (9 << 4) | 32'h1);
        wr(2, 32'h5000_0000 | (4 << 4) | 32'h1);
        wr(3, 16'h0080 | (3'b101 << 1) | 16'h1);
        wr(4, 16'h5001);
        xl(32'h5000_0123, "R8 window0 over window1");
        xl(32'h50FF_FFFF, "R8 window0 over io");
        wr(2, 32'h6100_0000 | (4 << 4) | 32'h1);
        wr(4, 16'h6101);
        xl(32'h6100_0123, "R8 window1 over io");
        xl(32'h6100_0FFE, "R5 low enable set");
        sweep_nibbles("R8 overlap");

        // Size sweep including reserved codes: R3 R4 R5 R9 R10
        wr(2, 32'h0); wr(4, 16'h0);
        for (int s = 0; s < 16; s++) begin
            longint unsigned sz = 64'd1 << (20 + (s > 11 ? 11 : s));
            longint unsigned b  = 64'hC030_0000;
            longint unsigned lo = (b / sz) * sz;
            string tg = (s > 11) ? "R9 reserved size" : "R3 R4 size sweep";
            wr(0, 32'hC030_0000 | (32'(s & 3) << 8) | (32'(s) << 4) | 32'h9);
            wr(1, 16'hA5A0 | (3'b011 << 1) | 16'(s & 1));
            xl(lo[31:0], tg);
            xl(32'(lo + sz - 1), tg);
            xl(32'(lo + sz), tg);
            xl(32'(lo - 1), tg);
            xl(32'(lo + 3), tg);
        end

        // R10: disabled window misses
        wr(0, 32'hC030_0090);
        xl(32'hC030_0000, "R10 disabled");
        xl(32'h0000_0000, "R10 nothing");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule